// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This block is a write-triggered 2D drawing accelerator for a framebuffer that stores one byte per pixel, with an optional 32-bit-per-pixel plane beside it and, behind that, a control plane of the same shape. Each command arrives on a valid/ready stream carrying a bus address, a 32-bit data word and a two-bit opcode. The bus address carries the destination pixel, so the data word is free for a pattern or a source descriptor. A stipple command expands a 32-bit mask into up to 32 colour writes. A blit command either fills a run of 1 to 32 pixels with the colour register or copies such a run from a source pixel address.

The engine turns each command into a sequence of pixel memory reads and writes, one pixel per clock in ascending address order, and holds `busy` high until the last write. The command stream has back-pressure: `cmd_ready` is low for as long as `busy` is high, so a producer must hold `cmd_valid` and its payload stable until a cycle in which both are high. A colour-register load is accepted in one cycle and never raises `busy`.

The memory port reads with a latency of one cycle: data for a read issued in one cycle must be on the read-data inputs during the next cycle. A read and a write to the same address in the same cycle must return the value from before the write. All pixel addresses wrap modulo the pixel memory size.

Top module: `pe_engine`

## Requirements
- R1: The destination pixel address is bus address bits [PIX_AW+2:3]. Addresses wrap modulo 2^PIX_AW, so a run that passes the top pixel continues at pixel 0.
- R2: A stipple command (cmd_op bit 0 = 0) covers pixels dest+0 to dest+31. Data bit 31 controls dest+0, and each lower bit controls the next pixel up. A set bit writes the colour register to its pixel. A clear bit leaves its pixel unchanged.
- R3: For a blit command (cmd_op bit 0 = 1), data bits [23:0] are the source pixel address and bits [28:24] hold the run length minus one, so a run is 1 to 32 pixels long.
- R4: A blit whose source field is 0xFFFFFF fills the run with the colour register. Any other source value copies the run from the source pixels to the destination pixels.
- R5: When depth24 is high, fills and stipples also write the low 24 bits of the colour, zero-extended, to the 32-bit plane, and copies also copy the 32-bit plane. When depth24 is low, only the byte plane changes.
- R6: A raw command (cmd_op bit 1 = 1) with depth24 high also writes or copies the control plane, in the same way as the 32-bit plane. A raw command with depth24 low leaves the control plane unchanged.
- R7: A command whose bus address bit 2 is set loads the colour register from the data word. It writes no pixels and does not raise busy. The colour register is 0 after reset. The byte plane uses colour bits [7:0].
- R8: Pixels are handled one per clock in ascending address order. Busy lasts 32 cycles for a stipple, len cycles for a fill and len+1 cycles for a copy. cmd_ready is low while busy is high.
- R9: A copy gives the same result as an ascending copy done one pixel at a time, including when the source and destination runs overlap in either direction.
- R10: After reset, busy is low, cmd_ready is high, and no read or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth24 | input | 1 | Enables writes to the 32-bit plane; held stable while busy |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | Bit 0: blit (1) or stipple (0); bit 1: raw variant |
| cmd_addr | input | PIX_AW+3 | Bus address; bits [PIX_AW+2:3] give the destination, bit 2 selects a colour load |
| cmd_data | input | 32 | Pattern, blit descriptor or colour |
| busy | output | 1 | High while a command is being executed |
| mem_rd_en | output | 1 | Pixel read request |
| mem_rd_addr | output | PIX_AW | Pixel read address |
| mem_rdata8 | input | 8 | Byte-plane read data, one cycle after the request |
| mem_rdata24 | input | 32 | 32-bit-plane read data |
| mem_rdatacp | input | 32 | Control-plane read data |
| mem_we8 | output | 1 | Byte-plane write enable |
| mem_we24 | output | 1 | 32-bit-plane write enable |
| mem_wecp | output | 1 | Control-plane write enable |
| mem_wr_addr | output | PIX_AW | Pixel write address |
| mem_wdata8 | output | 8 | Byte-plane write data |
| mem_wdata24 | output | 32 | 32-bit-plane write data |
| mem_wdatacp | output | 32 | Control-plane write data |

## Verification
The assertions assume that depth24 does not change while a command is in flight. They also assume that the memory returns read data exactly one cycle after a request, with the old value on a read that collides with a write. The bench changes depth24 only while the engine is idle. Its memory model registers read data on the cycle after the request, and a same-address write in that cycle does not change the data read. Random commands use any opcode and address, and a quarter of the blits are forced to the fill value. Directed cases cover copies whose runs overlap by one pixel in each direction and a run that wraps past the top address.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    K_STIP = 2'd0,
    K_FILL = 2'd1,
    K_COPY = 2'd2
  } pe_kind_e;

  localparam int          DST_SHIFT   = 3;
  localparam int          COL_SEL_BIT = 2;
  localparam logic [23:0] FILL_SRC    = 24'hFFFFFF;
  localparam int          STIP_LEN    = 32;
  localparam int          LEN_W       = 6;
endpackage

// File: rtl/pe_decode.sv
module pe_decode
  import pe_pkg::*;
#(
  parameter int PIX_AW = 20
) (
  input  logic [PIX_AW+DST_SHIFT-1:0] cmd_addr,
  input  logic [31:0]                 cmd_data,
  input  logic [1:0]                  cmd_op,
  output logic                        is_colour,
  output pe_kind_e                    kind,
  output logic                        raw,
  output logic [PIX_AW-1:0]           dst,
  output logic [PIX_AW-1:0]           src,
  output logic [LEN_W-1:0]            len
);
  always_comb begin
    is_colour = cmd_addr[COL_SEL_BIT];
    dst       = cmd_addr[DST_SHIFT +: PIX_AW];
    src       = cmd_data[PIX_AW-1:0];
    raw       = cmd_op[1];
    if (!cmd_op[0]) begin
      kind = K_STIP;
      len  = LEN_W'(STIP_LEN);
    end else begin
      kind = (cmd_data[23:0] == FILL_SRC) ? K_FILL : K_COPY;
      len  = {1'b0, cmd_data[28:24]} + 1'b1;
    end
  end
endmodule

// File: rtl/pe_seq.sv
module pe_seq
  import pe_pkg::*;
#(
  parameter int PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pe_kind_e          kind_in,
  input  logic              raw_in,
  input  logic              deep_in,
  input  logic [PIX_AW-1:0] dst_in,
  input  logic [PIX_AW-1:0] src_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [31:0]       pat_in,
  output logic              busy,
  output pe_kind_e          kind_q,
  output logic              raw_q,
  output logic              deep_q,
  output logic              rd_en,
  output logic [PIX_AW-1:0] rd_addr,
  output logic              wr_en,
  output logic [PIX_AW-1:0] wr_addr
);
  logic [PIX_AW-1:0] dst_q, src_q;
  logic [LEN_W-1:0]  len_q, idx_q, steps, wr_idx;
  logic [31:0]       pat_q;
  logic              is_copy, last;

  always_comb begin
    is_copy = (kind_q == K_COPY);
    steps   = is_copy ? len_q + 1'b1 : len_q;
    last    = (idx_q == steps - 1'b1);
    wr_idx  = is_copy ? idx_q - 1'b1 : idx_q;
    rd_en   = busy && is_copy && (idx_q < len_q);
    rd_addr = src_q + PIX_AW'(idx_q);
    wr_addr = dst_q + PIX_AW'(wr_idx);
    if (!busy)                 wr_en = 1'b0;
    else if (is_copy)          wr_en = (idx_q != '0);
    else if (kind_q == K_FILL) wr_en = 1'b1;
    else                       wr_en = pat_q[31];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      kind_q <= K_STIP;
      raw_q  <= 1'b0;
      deep_q <= 1'b0;
      dst_q  <= '0;
      src_q  <= '0;
      len_q  <= '0;
      pat_q  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      kind_q <= kind_in;
      raw_q  <= raw_in;
      deep_q <= deep_in;
      dst_q  <= dst_in;
      src_q  <= src_in;
      len_q  <= len_in;
      pat_q  <= pat_in;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      idx_q <= idx_q + 1'b1;
      pat_q <= {pat_q[30:0], 1'b0};
    end
  end
endmodule

// File: rtl/pe_wgen.sv
module pe_wgen
  import pe_pkg::*;
#(
  parameter int PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pe_kind_e          kind,
  input  logic              raw,
  input  logic              deep,
  input  logic [31:0]       colour,
  input  logic              rd_en,
  input  logic [PIX_AW-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [PIX_AW-1:0] wr_addr,
  input  logic [7:0]        rdata8,
  input  logic [31:0]       rdata24,
  input  logic [31:0]       rdatacp,
  output logic              we8,
  output logic              we24,
  output logic              wecp,
  output logic [7:0]        wdata8,
  output logic [31:0]       wdata24,
  output logic [31:0]       wdatacp
);
  logic        fwd_q;
  logic [7:0]  fwd8_q;
  logic [31:0] fwd24_q, fwdcp_q;

  always_comb begin
    we8  = wr_en;
    we24 = wr_en && deep;
    wecp = wr_en && deep && raw;
    if (kind == K_COPY) begin
      wdata8  = fwd_q ? fwd8_q  : rdata8;
      wdata24 = fwd_q ? fwd24_q : rdata24;
      wdatacp = fwd_q ? fwdcp_q : rdatacp;
    end else begin
      wdata8  = colour[7:0];
      wdata24 = {8'h00, colour[23:0]};
      wdatacp = {8'h00, colour[23:0]};
    end
  end

  // a read that meets a same-cycle write sees stale memory data; keep the new value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q   <= 1'b0;
      fwd8_q  <= '0;
      fwd24_q <= '0;
      fwdcp_q <= '0;
    end else begin
      fwd_q   <= rd_en && wr_en && (rd_addr == wr_addr);
      fwd8_q  <= wdata8;
      fwd24_q <= wdata24;
      fwdcp_q <= wdatacp;
    end
  end
endmodule

// File: rtl/pe_engine.sv
module pe_engine
  import pe_pkg::*;
#(
  parameter int PIX_AW = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        depth24,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [1:0]                  cmd_op,
  input  logic [PIX_AW+DST_SHIFT-1:0] cmd_addr,
  input  logic [31:0]                 cmd_data,
  output logic                        busy,
  output logic                        mem_rd_en,
  output logic [PIX_AW-1:0]           mem_rd_addr,
  input  logic [7:0]                  mem_rdata8,
  input  logic [31:0]                 mem_rdata24,
  input  logic [31:0]                 mem_rdatacp,
  output logic                        mem_we8,
  output logic                        mem_we24,
  output logic                        mem_wecp,
  output logic [PIX_AW-1:0]           mem_wr_addr,
  output logic [7:0]                  mem_wdata8,
  output logic [31:0]                 mem_wdata24,
  output logic [31:0]                 mem_wdatacp
);
  logic              accept, start, is_colour, d_raw, s_raw, s_deep, wr_en;
  pe_kind_e          d_kind, s_kind;
  logic [PIX_AW-1:0] d_dst, d_src;
  logic [LEN_W-1:0]  d_len;
  logic [31:0]       colour_q;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && !is_colour;

  always_ff @(posedge clk) begin
    if (!rst_n)                  colour_q <= '0;
    else if (accept && is_colour) colour_q <= cmd_data;
  end

  pe_decode #(.PIX_AW(PIX_AW)) u_dec (
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd_op   (cmd_op),
    .is_colour(is_colour),
    .kind     (d_kind),
    .raw      (d_raw),
    .dst      (d_dst),
    .src      (d_src),
    .len      (d_len)
  );

  pe_seq #(.PIX_AW(PIX_AW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .kind_in(d_kind),
    .raw_in (d_raw),
    .deep_in(depth24),
    .dst_in (d_dst),
    .src_in (d_src),
    .len_in (d_len),
    .pat_in (cmd_data),
    .busy   (busy),
    .kind_q (s_kind),
    .raw_q  (s_raw),
    .deep_q (s_deep),
    .rd_en  (mem_rd_en),
    .rd_addr(mem_rd_addr),
    .wr_en  (wr_en),
    .wr_addr(mem_wr_addr)
  );

  pe_wgen #(.PIX_AW(PIX_AW)) u_wgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (s_kind),
    .raw    (s_raw),
    .deep   (s_deep),
    .colour (colour_q),
    .rd_en  (mem_rd_en),
    .rd_addr(mem_rd_addr),
    .wr_en  (wr_en),
    .wr_addr(mem_wr_addr),
    .rdata8 (mem_rdata8),
    .rdata24(mem_rdata24),
    .rdatacp(mem_rdatacp),
    .we8    (mem_we8),
    .we24   (mem_we24),
    .wecp   (mem_wecp),
    .wdata8 (mem_wdata8),
    .wdata24(mem_wdata24),
    .wdatacp(mem_wdatacp)
  );
endmodule

// File: rtl/pe_engine_chk.sv
module pe_engine_chk #(
  parameter int PIX_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              depth24,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [PIX_AW+2:0] cmd_addr,
  input logic              busy,
  input logic              mem_rd_en,
  input logic              mem_we8,
  input logic              mem_we24,
  input logic              mem_wecp,
  input logic [PIX_AW-1:0] mem_wr_addr
);
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_addr[2]) |=> busy);

  assert_colour_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_addr[2]) |=> !busy);

  assert_busy_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  assert_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mem_we8 && $past(mem_we8))
      |-> (mem_wr_addr == PIX_AW'($past(mem_wr_addr) + 1'b1)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd_en || mem_we8 || mem_we24 || mem_wecp));

  assert_deep_plane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we24 |-> (mem_we8 && depth24));

  assert_ctrl_plane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wecp |-> mem_we24);
endmodule

bind pe_engine pe_engine_chk #(.PIX_AW(PIX_AW)) u_chk (.*);

// File: tb/pe_engine_tb.sv
module pe_engine_tb;
  localparam int AW = 10;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          depth24 = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [AW+2:0] cmd_addr = '0;
  logic [31:0]   cmd_data = '0;
  logic          busy;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]    mem_rdata8, mem_wdata8;
  logic [31:0]   mem_rdata24, mem_rdatacp, mem_wdata24, mem_wdatacp;
  logic          mem_we8, mem_we24, mem_wecp;

  logic [7:0]  m8 [N];
  logic [31:0] m24[N];
  logic [31:0] mcp[N];
  logic [7:0]  r8 [N];
  logic [31:0] r24[N];
  logic [31:0] rcp[N];
  logic [31:0] ref_col = 32'h0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pe_engine #(.PIX_AW(AW)) u_dut (.*);

  function automatic logic [7:0]  init8 (int i); return 8'(i * 37 + 5); endfunction
  function automatic logic [31:0] init24(int i); return 32'(i) * 32'h9E3779B1; endfunction
  function automatic logic [31:0] initcp(int i); return (32'(i) * 32'h85EBCA6B) ^ 32'hDEAD; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m8[i]  <= init8(i);
        m24[i] <= init24(i);
        mcp[i] <= initcp(i);
      end
    end else begin
      if (mem_rd_en) begin
        mem_rdata8  <= m8[mem_rd_addr];
        mem_rdata24 <= m24[mem_rd_addr];
        mem_rdatacp <= mcp[mem_rd_addr];
      end
      if (mem_we8)  m8[mem_wr_addr]  <= mem_wdata8;
      if (mem_we24) m24[mem_wr_addr] <= mem_wdata24;
      if (mem_wecp) mcp[mem_wr_addr] <= mem_wdatacp;
    end
  end

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_apply(input logic [1:0] op, input logic [AW+2:0] addr,
                                   input logic [31:0] data, input logic deep);
    int dst, src, len;
    logic [31:0] c24;
    if (addr[2]) begin
      ref_col = data;
      return 0;
    end
    dst = int'(addr[AW+2:3]);
    c24 = {8'h00, ref_col[23:0]};
    if (!op[0]) begin
      for (int i = 0; i < 32; i++) begin
        if (data[31-i]) begin
          r8[(dst+i)%N] = ref_col[7:0];
          if (deep) r24[(dst+i)%N] = c24;
          if (deep && op[1]) rcp[(dst+i)%N] = c24;
        end
      end
      return 32;
    end
    len = int'(data[28:24]) + 1;
    if (data[23:0] == 24'hFFFFFF) begin
      for (int i = 0; i < len; i++) begin
        r8[(dst+i)%N] = ref_col[7:0];
        if (deep) r24[(dst+i)%N] = c24;
        if (deep && op[1]) rcp[(dst+i)%N] = c24;
      end
      return len;
    end
    src = int'(data[AW-1:0]);
    for (int i = 0; i < len; i++) begin
      r8[(dst+i)%N] = r8[(src+i)%N];
      if (deep) r24[(dst+i)%N] = r24[(src+i)%N];
      if (deep && op[1]) rcp[(dst+i)%N] = rcp[(src+i)%N];
    end
    return len + 1;
  endfunction

  task automatic run_cmd(input string tag, input logic [1:0] op,
                         input logic [AW+2:0] addr, input logic [31:0] data);
    int cyc, exp_cyc, miss, first;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = addr;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    exp_cyc = ref_apply(op, addr, data, depth24);
    check({tag, " R8 busy cycles"}, cyc == exp_cyc, cyc, exp_cyc);
    miss = 0;
    first = -1;
    for (int i = 0; i < N; i++) begin
      if (m8[i] !== r8[i] || m24[i] !== r24[i] || mcp[i] !== rcp[i]) begin
        miss++;
        if (first < 0) first = i;
      end
    end
    if (miss != 0)
      $display("  first mismatch at pixel %0d: got %h/%h/%h want %h/%h/%h", first,
               m8[first], m24[first], mcp[first], r8[first], r24[first], rcp[first]);
    check({tag, " memory image mismatches"}, miss == 0, miss, 0);
  endtask

  function automatic logic [AW+2:0] pix(input int p);
    return {AW'(p), 3'b000};
  endfunction

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin
      r8[i] = init8(i);
      r24[i] = init24(i);
      rcp[i] = initcp(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle after reset
    check("R10 busy after reset", busy == 1'b0, busy, 0);
    check("R10 ready after reset", cmd_ready == 1'b1, cmd_ready, 1);
    check("R10 no traffic after reset",
          !(mem_rd_en || mem_we8 || mem_we24 || mem_wecp), 1, 0);

    // R7: colour register is 0 after reset; fill in depth 8 shows it
    run_cmd("R7 R4 fill with reset colour", 2'b01, pix(20), {3'b000, 5'd3, 24'hFFFFFF});
    run_cmd("R7 colour load", 2'b00, pix(7) | 13'h4, 32'h00A1B2C3);
    // R2: stipple edges; R1 destination from bus address
    run_cmd("R2 R1 stipple edge bits", 2'b00, pix(100), 32'h8000_0001);
    run_cmd("R2 stipple zero pattern", 2'b00, pix(140), 32'h0000_0000);
    // R4 R3: fill of one pixel and of 32 pixels
    run_cmd("R4 R3 fill len 1", 2'b01, pix(200), {3'b000, 5'd0, 24'hFFFFFF});
    run_cmd("R4 R3 fill len 32", 2'b01, pix(300), {3'b000, 5'd31, 24'hFFFFFF});
    // R9: overlapping copies both ways
    run_cmd("R9 copy dst=src+1", 2'b01, pix(401), {3'b000, 5'd15, 24'd400});
    run_cmd("R9 copy dst=src-1", 2'b01, pix(499), {3'b000, 5'd15, 24'd500});
    // R5 R6: depth 24 planes
    @(negedge clk);
    depth24 = 1'b1;
    run_cmd("R5 colour load deep", 2'b00, pix(0) | 13'h4, 32'hFF5A6B7C);
    run_cmd("R5 fill deep", 2'b01, pix(600), {3'b000, 5'd4, 24'hFFFFFF});
    run_cmd("R6 raw stipple deep", 2'b10, pix(640), 32'hF0F0_1234);
    run_cmd("R6 raw copy deep", 2'b11, pix(700), {3'b000, 5'd9, 24'd640});
    run_cmd("R5 copy deep not raw", 2'b01, pix(720), {3'b000, 5'd9, 24'd600});
    // R1: wrap past top pixel
    run_cmd("R1 raw fill wraps", 2'b11, pix(N-3), {3'b000, 5'd7, 24'hFFFFFF});
    @(negedge clk);
    depth24 = 1'b0;
    run_cmd("R6 raw fill shallow", 2'b11, pix(800), {3'b000, 5'd5, 24'hFFFFFF});
    run_cmd("R1 copy wraps", 2'b01, pix(N-2), {3'b000, 5'd5, 24'd10});

    // random mix, checked against the reference model (R3 R4 R5 R6 R9)
    for (int k = 0; k < 200; k++) begin
      logic [1:0]    op;
      logic [AW+2:0] a;
      logic [31:0]   d;
      if (k % 40 == 0) begin
        @(negedge clk);
        depth24 = $urandom_range(0, 1) == 1;
      end
      op = 2'($urandom);
      a  = (AW+3)'($urandom);
      if ($urandom_range(0, 4) == 0) a[2] = 1'b1;
      else a[2] = 1'b0;
      d  = $urandom;
      if (op[0] && $urandom_range(0, 3) == 0) d[23:0] = 24'hFFFFFF;
      run_cmd("R3 random", op, a, d);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule